// File: doc/BRIEF.md
# Rename History Buffer with Squash and Commit Recovery

This block keeps an ordered record of every register rename made by an out-of-order core's rename stage. Each record holds an instruction sequence number, the architectural register that was written, the physical register newly given to it, the physical register that held the architectural value before, and a flag that marks a record with no register, used for instructions that write no destination. Records enter at the young end, one per cycle. An instruction with several destinations sends one record per destination. An instruction with none sends a single placeholder record that carries only its sequence number.

On a squash, the block walks from the young end and undoes each rename younger than the squash point. It drives a write to the external map table that puts back the previous physical register, and a write to the external free list that returns the new one. On a commit, the block walks from the old end and retires every record up to and including the committed sequence number. For each real record it returns the previous physical register to the free list. Both walks handle one record per cycle. While a walk runs, `busy` is high. The storage is a circular array of parameterised depth, and a `full` flag holds off the rename stage.

Top module: `rename_history`

## Requirements
- R1: After a synchronous reset, `full`, `busy`, `map_we` and `free_we` are all 0.
- R2: A push is taken when `push_valid` is 1, `full` is 0, `busy` is 0 and neither `squash_req` nor `commit_req` is 1. Records are kept in push order, so an instruction with several destinations occupies several consecutive records.
- R3: `full` is 1 once DEPTH records are held. A push while `full` is 1 is dropped and never later appears on any output.
- R4: A squash with limit S removes records from the young end, one per cycle, while the youngest record's sequence number is greater than S (plain unsigned compare). For each removed real record, `map_we` and `free_we` pulse together in the same cycle, with `map_arch` set to the record's architectural register, `map_phys` set to its previous physical register, and `free_phys` set to its new physical register.
- R5: A placeholder record (push_hold = 1) is removed by a squash or a commit without any pulse on `map_we` or `free_we`.
- R6: A commit with limit C removes records from the old end, one per cycle, while the oldest record's sequence number is at most C. Each removed real record pulses `free_we` with `free_phys` set to its previous physical register. `map_we` stays 0.
- R7: A commit request is ignored when the buffer is empty or when the oldest record's sequence number is greater than C. `busy` stays 0, nothing is written, and the records remain for later walks.
- R8: A squash request on an empty buffer produces no writes, and `busy` returns to 0.
- R9: `busy` rises in the cycle after a request is accepted. It stays high for one cycle per removed record plus one final cycle, and falls after that. Requests and pushes that arrive while `busy` is 1 are ignored. Write pulses appear only while `busy` is 1.
- R10: When `squash_req` and `commit_req` arrive in the same cycle, the squash is taken and the commit is dropped. A push that arrives in the same cycle as either request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Rename record offered |
| push_hold | input | 1 | Record is a placeholder with no destination |
| push_seq | input | SEQ_W | Sequence number of the renamed instruction |
| push_arch | input | ARCH_W | Architectural destination register |
| push_new | input | PHYS_W | Newly assigned physical register |
| push_prev | input | PHYS_W | Physical register previously mapped |
| full | output | 1 | Buffer holds DEPTH records |
| squash_req | input | 1 | Start a squash walk |
| squash_seq | input | SEQ_W | Squash limit; records above it are undone |
| commit_req | input | 1 | Start a commit walk |
| commit_seq | input | SEQ_W | Commit limit; records at or below it retire |
| busy | output | 1 | A walk is in progress |
| map_we | output | 1 | Map table restore strobe |
| map_arch | output | ARCH_W | Architectural register to restore |
| map_phys | output | PHYS_W | Physical register to restore into the map |
| free_we | output | 1 | Free list return strobe |
| free_phys | output | PHYS_W | Physical register returned to the free list |

## Verification
A squash is run over a mix of real and placeholder records that includes a two-destination instruction. The order of the restore writes shows that removal runs young to old, and the values written show that the previous and new registers go to the right ports. A commit is run first with a limit that covers only part of the buffer, then with a limit below the oldest record, and then against a placeholder. These three cases separate the stop rule, the ignore rule and the no-write rule. A full buffer is committed in one walk to show that the dropped push never appears, and a same-cycle squash, commit and push shows which request wins. A walk that is started while another is running shows that `busy` lasts the expected number of cycles and that requests and pushes made during it are dropped.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_UNDO   = 2'd1,
    WALK_RETIRE = 2'd2
  } walk_state_t;
endpackage

// File: rtl/rhb_store.sv
module rhb_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_old,
  input  logic [AW-1:0]    raddr_young,
  output logic [WIDTH-1:0] rdata_old,
  output logic [WIDTH-1:0] rdata_young
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_old   = mem[raddr_old];
  assign rdata_young = mem[raddr_young];
endmodule

// File: rtl/rhb_ptrs.sv
module rhb_ptrs #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop_old,
  input  logic          pop_young,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] old_idx,
  output logic [AW-1:0] young_idx,
  output logic          empty,
  output logic          full
);
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (push) begin
      wr_q  <= wr_q + 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_old) begin
      rd_q  <= rd_q + 1'b1;
      cnt_q <= cnt_q - 1'b1;
    end else if (pop_young) begin
      wr_q  <= wr_q - 1'b1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign wr_idx    = wr_q;
  assign old_idx   = rd_q;
  assign young_idx = wr_q - 1'b1;
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/rhb_walk.sv
module rhb_walk #(
  parameter int SEQ_W  = 16,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              empty,
  input  logic              squash_req,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              commit_req,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              old_hold,
  input  logic [SEQ_W-1:0]  old_seq,
  input  logic [PHYS_W-1:0] old_prev,
  input  logic              yng_hold,
  input  logic [SEQ_W-1:0]  yng_seq,
  input  logic [ARCH_W-1:0] yng_arch,
  input  logic [PHYS_W-1:0] yng_new,
  input  logic [PHYS_W-1:0] yng_prev,
  output logic              idle,
  output logic              pop_old,
  output logic              pop_young,
  output logic              map_we,
  output logic [ARCH_W-1:0] map_arch,
  output logic [PHYS_W-1:0] map_phys,
  output logic              free_we,
  output logic [PHYS_W-1:0] free_phys
);
  import rhb_pkg::*;

  walk_state_t      state_q;
  logic [SEQ_W-1:0] limit_q;
  logic             commit_ok;

  assign idle      = (state_q == WALK_IDLE);
  assign commit_ok = !empty && (old_seq <= commit_seq);
  assign pop_young = (state_q == WALK_UNDO)   && !empty && (yng_seq > limit_q);
  assign pop_old   = (state_q == WALK_RETIRE) && !empty && (old_seq <= limit_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= WALK_IDLE;
      limit_q   <= '0;
      map_we    <= 1'b0;
      map_arch  <= '0;
      map_phys  <= '0;
      free_we   <= 1'b0;
      free_phys <= '0;
    end else begin
      map_we  <= 1'b0;
      free_we <= 1'b0;
      unique case (state_q)
        WALK_IDLE: begin
          if (squash_req) begin
            state_q <= WALK_UNDO;
            limit_q <= squash_seq;
          end else if (commit_req && commit_ok) begin
            state_q <= WALK_RETIRE;
            limit_q <= commit_seq;
          end
        end
        WALK_UNDO: begin
          if (pop_young) begin
            if (!yng_hold) begin
              map_we    <= 1'b1;
              map_arch  <= yng_arch;
              map_phys  <= yng_prev;
              free_we   <= 1'b1;
              free_phys <= yng_new;
            end
          end else begin
            state_q <= WALK_IDLE;
          end
        end
        WALK_RETIRE: begin
          if (pop_old) begin
            if (!old_hold) begin
              free_we   <= 1'b1;
              free_phys <= old_prev;
            end
          end else begin
            state_q <= WALK_IDLE;
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rename_history.sv
module rename_history #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic              push_hold,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [ARCH_W-1:0] push_arch,
  input  logic [PHYS_W-1:0] push_new,
  input  logic [PHYS_W-1:0] push_prev,
  output logic              full,
  input  logic              squash_req,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              commit_req,
  input  logic [SEQ_W-1:0]  commit_seq,
  output logic              busy,
  output logic              map_we,
  output logic [ARCH_W-1:0] map_arch,
  output logic [PHYS_W-1:0] map_phys,
  output logic              free_we,
  output logic [PHYS_W-1:0] free_phys
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = 1 + SEQ_W + ARCH_W + 2 * PHYS_W;

  logic [AW-1:0] wr_idx, old_idx, young_idx;
  logic          empty, idle, pop_old, pop_young, push_take;
  logic [EW-1:0] rec_in, rec_old, rec_yng;

  assign push_take = push_valid && !full && idle && !squash_req && !commit_req;
  assign rec_in    = {push_hold, push_seq, push_arch, push_new, push_prev};
  assign busy      = !idle;

  rhb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push(push_take), .pop_old(pop_old),
    .pop_young(pop_young), .wr_idx(wr_idx), .old_idx(old_idx),
    .young_idx(young_idx), .empty(empty), .full(full)
  );

  rhb_store #(.DEPTH(DEPTH), .WIDTH(EW)) u_store (
    .clk(clk), .we(push_take), .waddr(wr_idx), .wdata(rec_in),
    .raddr_old(old_idx), .raddr_young(young_idx),
    .rdata_old(rec_old), .rdata_young(rec_yng)
  );

  rhb_walk #(.SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)) u_walk (
    .clk(clk), .rst(rst), .empty(empty),
    .squash_req(squash_req), .squash_seq(squash_seq),
    .commit_req(commit_req), .commit_seq(commit_seq),
    .old_hold(rec_old[EW-1]),
    .old_seq(rec_old[EW-2 -: SEQ_W]),
    .old_prev(rec_old[PHYS_W-1:0]),
    .yng_hold(rec_yng[EW-1]),
    .yng_seq(rec_yng[EW-2 -: SEQ_W]),
    .yng_arch(rec_yng[2*PHYS_W +: ARCH_W]),
    .yng_new(rec_yng[PHYS_W +: PHYS_W]),
    .yng_prev(rec_yng[PHYS_W-1:0]),
    .idle(idle), .pop_old(pop_old), .pop_young(pop_young),
    .map_we(map_we), .map_arch(map_arch), .map_phys(map_phys),
    .free_we(free_we), .free_phys(free_phys)
  );
endmodule

// File: rtl/rhb_checker.sv
module rhb_checker (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic full,
  input logic squash_req,
  input logic commit_req,
  input logic map_we,
  input logic free_we
);
  a_r9_writes_in_walk: assert property (@(posedge clk) disable iff (rst)
    (map_we || free_we) |-> busy);

  a_r4_restore_paired: assert property (@(posedge clk) disable iff (rst)
    map_we |-> free_we);

  a_r9_clean_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!map_we && !free_we));

  a_r9_busy_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(squash_req || commit_req));

  a_r3_full_hold: assert property (@(posedge clk) disable iff (rst)
    (full && !busy && !squash_req && !commit_req) |=> full);
endmodule

bind rename_history rhb_checker i_rhb_checker (
  .clk(clk), .rst(rst), .busy(busy), .full(full),
  .squash_req(squash_req), .commit_req(commit_req),
  .map_we(map_we), .free_we(free_we)
);

// File: tb/test_rename_history.sv
module test_rename_history;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 8;
  localparam int SW = 8;
  localparam int AW = 5;
  localparam int PW = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic push_valid = 1'b0, push_hold = 1'b0;
  logic [SW-1:0] push_seq = '0;
  logic [AW-1:0] push_arch = '0;
  logic [PW-1:0] push_new = '0, push_prev = '0;
  logic squash_req = 1'b0, commit_req = 1'b0;
  logic [SW-1:0] squash_seq = '0, commit_seq = '0;
  logic full, busy, map_we, free_we;
  logic [AW-1:0] map_arch;
  logic [PW-1:0] map_phys, free_phys;

  int checks = 0, errors = 0;
  int fcnt = 0, mcnt = 0, bcnt = 0;
  logic [PW-1:0] flog [64];
  logic [AW-1:0] alog [64];
  logic [PW-1:0] plog [64];
  bit done = 1'b0;

  rename_history #(.DEPTH(D), .SEQ_W(SW), .ARCH_W(AW), .PHYS_W(PW)) i_rename_history (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_hold(push_hold),
    .push_seq(push_seq), .push_arch(push_arch), .push_new(push_new),
    .push_prev(push_prev), .full(full), .squash_req(squash_req),
    .squash_seq(squash_seq), .commit_req(commit_req), .commit_seq(commit_seq),
    .busy(busy), .map_we(map_we), .map_arch(map_arch), .map_phys(map_phys),
    .free_we(free_we), .free_phys(free_phys)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (free_we && fcnt < 64) begin flog[fcnt] = free_phys; fcnt++; end
      if (map_we && mcnt < 64) begin alog[mcnt] = map_arch; plog[mcnt] = map_phys; mcnt++; end
      if (busy) bcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    fcnt = 0; mcnt = 0; bcnt = 0;
  endtask

  task automatic push(input int seq, input bit ph, input int arch, input int nw, input int pv);
    @(negedge clk);
    push_valid = 1'b1; push_hold = ph; push_seq = SW'(seq);
    push_arch = AW'(arch); push_new = PW'(nw); push_prev = PW'(pv);
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic squash(input int s);
    @(negedge clk);
    squash_req = 1'b1; squash_seq = SW'(s);
    @(negedge clk);
    squash_req = 1'b0;
    wait_idle();
  endtask

  task automatic commit(input int c);
    @(negedge clk);
    commit_req = 1'b1; commit_seq = SW'(c);
    @(negedge clk);
    commit_req = 1'b0;
    wait_idle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!full && !busy && !map_we && !free_we, "R1", "outputs after reset",
        int'({full, busy, map_we, free_we}), 0);
  endtask

  task automatic t_empty_walks();
    clear_log();
    squash(5);
    chk(fcnt == 0 && mcnt == 0, "R8", "writes on empty squash", fcnt + mcnt, 0);
    chk(!busy, "R8", "busy after empty squash", int'(busy), 0);
    clear_log();
    commit(9);
    chk(bcnt == 0, "R7", "busy cycles on empty commit", bcnt, 0);
    chk(fcnt == 0, "R7", "frees on empty commit", fcnt, 0);
  endtask

  task automatic t_squash_commit();
    push(1, 0, 3, 10, 3);
    push(2, 1, 0, 0, 0);
    push(3, 0, 4, 11, 4);
    push(3, 0, 5, 12, 5);
    push(4, 0, 3, 13, 10);
    clear_log();
    squash(2);
    chk(mcnt == 3 && fcnt == 3, "R4", "restore count", mcnt, 3);
    chk(alog[0] == 3 && plog[0] == 10 && flog[0] == 13, "R4", "youngest restore phys", int'(plog[0]), 10);
    chk(alog[1] == 5 && plog[1] == 5 && flog[1] == 12, "R2", "second dest of seq 3 undone", int'(flog[1]), 12);
    chk(alog[2] == 4 && plog[2] == 4 && flog[2] == 11, "R4", "first dest of seq 3 undone", int'(flog[2]), 11);
    clear_log();
    commit(1);
    chk(fcnt == 1 && flog[0] == 3, "R6", "commit frees previous phys", int'(flog[0]), 3);
    chk(mcnt == 0, "R6", "commit map writes", mcnt, 0);
    clear_log();
    commit(0);
    chk(bcnt == 0 && fcnt == 0, "R7", "commit below oldest ignored", bcnt + fcnt, 0);
    clear_log();
    commit(2);
    chk(fcnt == 0 && mcnt == 0 && bcnt == 2, "R5", "placeholder retire writes/busy", fcnt * 100 + mcnt * 10 + bcnt, 2);
    clear_log();
    squash(0);
    chk(fcnt == 0, "R8", "buffer emptied by placeholder retire", fcnt, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < D; i++) push(10 + i, 0, i, 20 + i, i);
    chk(full, "R3", "full after DEPTH pushes", int'(full), 1);
    push(18, 0, 9, 40, 40);
    clear_log();
    commit(255);
    chk(fcnt == D, "R3", "frees after full commit", fcnt, D);
    for (int i = 0; i < D; i++)
      chk(flog[i] == PW'(i), "R6", "oldest-first free order", int'(flog[i]), i);
    chk(!full, "R3", "full after drain", int'(full), 0);
  endtask

  task automatic t_priority();
    push(30, 0, 1, 50, 1);
    push(31, 0, 2, 51, 2);
    clear_log();
    @(negedge clk);
    squash_req = 1'b1; squash_seq = SW'(30);
    commit_req = 1'b1; commit_seq = SW'(31);
    push_valid = 1'b1; push_hold = 1'b0; push_seq = SW'(32);
    push_arch = AW'(7); push_new = PW'(52); push_prev = PW'(52);
    @(negedge clk);
    squash_req = 1'b0; commit_req = 1'b0; push_valid = 1'b0;
    wait_idle();
    chk(mcnt == 1 && alog[0] == 2 && plog[0] == 2, "R10", "squash wins restore", mcnt, 1);
    chk(fcnt == 1 && flog[0] == 51, "R10", "squash wins free", int'(flog[0]), 51);
    clear_log();
    commit(40);
    chk(fcnt == 1 && flog[0] == 1, "R10", "same-cycle push dropped", fcnt, 1);
  endtask

  task automatic t_busy();
    for (int i = 0; i < 4; i++) push(50 + i, 0, i, 30 + i, 40 + i);
    clear_log();
    @(negedge clk);
    squash_req = 1'b1; squash_seq = SW'(49);
    @(negedge clk);
    squash_req = 1'b0;
    commit_req = 1'b1; commit_seq = SW'(255);
    push_valid = 1'b1; push_seq = SW'(60); push_new = PW'(61); push_prev = PW'(62);
    @(negedge clk);
    commit_req = 1'b0; push_valid = 1'b0;
    wait_idle();
    chk(bcnt == 5, "R9", "busy cycles for four pops", bcnt, 5);
    chk(fcnt == 4 && mcnt == 4, "R9", "one write per popped record", fcnt, 4);
    clear_log();
    commit(255);
    chk(fcnt == 0 && bcnt == 0, "R9", "request and push during walk ignored", fcnt + bcnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_empty_walks();
    t_squash_commit();
    t_full();
    t_priority();
    t_busy();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule